// File: doc/BRIEF.md
# Line-Locked Pixel Clock Generator

This block derives a pixel timing grid from a fast, fixed reference clock through a phase accumulator. On every reference cycle a frequency word is added to a 24-bit phase register. Each carry out of that add produces a one-cycle pixel enable strobe, and the top bit of the phase register is brought out as a toggling pixel clock. Individual pixel periods may differ by one reference cycle, but the average rate is exact.

The grid is locked to each video line. The horizontal sync input is synchronised into the reference domain, and its active edge is picked by a polarity select. On that edge the phase register is loaded with a programmable phase offset in place of the normal sum, and a one-cycle line-start pulse is raised. The frequency word is captured only at these line starts, so the rate never changes inside a line. A word outside the legal 10 to 50 MHz band is clamped to the nearest edge of that band. The frequency word has no relation to the line length.

Top module: `dto_pixclk_gen`

## Requirements
- R1: While rst_ni is low and directly after it rises, pix_clk_o, pix_en_o and line_start_o are 0, the phase register is 0, and until the first line start the phase advances by the lower increment limit 838861 on every cycle.
- R2: With hsync_pol_i = 0 a rising hsync_i is active, and with hsync_pol_i = 1 a falling one is. line_start_o is 1 for exactly one cycle, becoming visible after the third rising clock edge that follows the change of hsync_i (two synchroniser stages plus the load register).
- R3: An hsync_i edge of the inactive direction produces no line_start_o and leaves the phase sequence untouched.
- R4: In the line-start cycle the phase register holds phase_ofs_i as sampled at the load edge, and pix_en_o is 0 even if the normal sum would have carried in that cycle.
- R5: In every other cycle the phase becomes (phase + inc) mod 2^24, and pix_en_o is 1 exactly in the cycle after an add that carried out of bit 23.
- R6: pix_clk_o equals bit 23 of the phase register.
- R7: inc_i is captured only at a line start; changes to it in mid-line have no effect on the pixel timing until the next line start.
- R8: A captured increment below 838861 (10 MHz at a 200 MHz reference) is replaced by 838861, and one above 4194304 (50 MHz) by 4194304.
- R9: Over M cycles after a line start with a zero phase offset, pix_en_o is high floor(M * inc / 2^24) times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, asynchronous to clk_i |
| hsync_pol_i | input | 1 | 0: rising edge active, 1: falling edge active |
| inc_i | input | 24 | Frequency word, round(f_pix / f_ref * 2^24) |
| phase_ofs_i | input | 24 | Phase loaded at each line start |
| pix_clk_o | output | 1 | Pixel clock, phase register MSB |
| pix_en_o | output | 1 | One-cycle pixel enable strobe on accumulator carry |
| line_start_o | output | 1 | One-cycle pulse marking a line start |

## Verification
The sync load and an accumulator carry can fall in the same reference cycle. If they do, the load must win: the strobe is suppressed and the phase takes the offset. The bench provokes this with the maximum increment 2^22, which carries every fourth cycle from a zero offset. It places the next active sync edge so that its load lands exactly on the eighth cycle of the line. The result is judged by requiring pix_en_o low, line_start_o high and pix_clk_o equal to the offset MSB in that cycle, with the carry pattern resuming from the offset afterwards.

// File: rtl/dto_pkg.sv
package dto_pkg;
  localparam int unsigned ACC_W_DEF   = 24;
  localparam int unsigned INC_MIN_DEF = 838861;   // 10 MHz at 200 MHz ref
  localparam int unsigned INC_MAX_DEF = 4194304;  // 50 MHz at 200 MHz ref

  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } hs_pol_e;
endpackage

// File: rtl/hsync_edge_det.sv
module hsync_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic pol_i,
  output logic edge_o
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               cur, prev;
  dto_pkg::hs_pol_e   pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CHAIN_W-2:0], hsync_i};
  end

  assign cur  = chain_q[SYNC_STAGES-1];
  assign prev = chain_q[SYNC_STAGES];
  assign pol  = dto_pkg::hs_pol_e'(pol_i);

  always_comb begin
    unique case (pol)
      dto_pkg::POL_RISE: edge_o = cur & ~prev;
      dto_pkg::POL_FALL: edge_o = ~cur & prev;
      default:           edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/inc_latch.sv
module inc_latch #(
  parameter int unsigned     ACC_W   = 24,
  parameter logic [ACC_W-1:0] INC_MIN = ACC_W'(838861),
  parameter logic [ACC_W-1:0] INC_MAX = ACC_W'(4194304)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] inc_q_o
);
  logic [ACC_W-1:0] inc_lim;

  always_comb begin
    if (inc_i < INC_MIN)      inc_lim = INC_MIN;
    else if (inc_i > INC_MAX) inc_lim = INC_MAX;
    else                      inc_lim = inc_i;
  end

  // capture only at line start: rate is constant across a line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inc_q_o <= INC_MIN;
    else if (load_i) inc_q_o <= inc_lim;
  end
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] ofs_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             carry_o
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_o} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      carry_o <= 1'b0;
    end else if (load_i) begin
      // load wins over a coincident carry
      acc_o   <= ofs_i;
      carry_o <= 1'b0;
    end else begin
      acc_o   <= sum[ACC_W-1:0];
      carry_o <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/dto_pixclk_gen.sv
module dto_pixclk_gen #(
  parameter int unsigned      ACC_W       = dto_pkg::ACC_W_DEF,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [ACC_W-1:0] INC_MIN     = ACC_W'(dto_pkg::INC_MIN_DEF),
  parameter logic [ACC_W-1:0] INC_MAX     = ACC_W'(dto_pkg::INC_MAX_DEF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             hsync_pol_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] phase_ofs_i,
  output logic             pix_clk_o,
  output logic             pix_en_o,
  output logic             line_start_o
);
  logic             sync_edge;
  logic [ACC_W-1:0] inc_q;
  logic [ACC_W-1:0] acc;
  logic             line_start_q;

  hsync_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hsync_i(hsync_i),
    .pol_i  (hsync_pol_i),
    .edge_o (sync_edge)
  );

  inc_latch #(.ACC_W(ACC_W), .INC_MIN(INC_MIN), .INC_MAX(INC_MAX)) u_inc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sync_edge),
    .inc_i  (inc_i),
    .inc_q_o(inc_q)
  );

  phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sync_edge),
    .ofs_i  (phase_ofs_i),
    .inc_i  (inc_q),
    .acc_o  (acc),
    .carry_o(pix_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_start_q <= 1'b0;
    else         line_start_q <= sync_edge;
  end

  assign line_start_o = line_start_q;
  assign pix_clk_o    = acc[ACC_W-1];
endmodule

// File: rtl/dto_pixclk_chk.sv
module dto_pixclk_chk #(
  parameter int unsigned      ACC_W   = 24,
  parameter logic [ACC_W-1:0] INC_MIN = ACC_W'(838861),
  parameter logic [ACC_W-1:0] INC_MAX = ACC_W'(4194304)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ofs_msb_i,
  input logic             pix_clk_o,
  input logic             pix_en_o,
  input logic             line_start_o,
  input logic [ACC_W-1:0] inc_q_i
);
  // R4
  line_start_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> !pix_en_o);

  // R2
  line_start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o);

  // R4
  line_start_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> (pix_clk_o == $past(ofs_msb_i)));

  // R7
  inc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_o |-> $stable(inc_q_i));

  // R8
  inc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> (inc_q_i >= INC_MIN) && (inc_q_i <= INC_MAX));
endmodule

bind dto_pixclk_gen dto_pixclk_chk #(
  .ACC_W  (ACC_W),
  .INC_MIN(INC_MIN),
  .INC_MAX(INC_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ofs_msb_i   (phase_ofs_i[ACC_W-1]),
  .pix_clk_o   (pix_clk_o),
  .pix_en_o    (pix_en_o),
  .line_start_o(line_start_o),
  .inc_q_i     (inc_q)
);

// File: tb/tb_dto_pixclk_gen.sv
`timescale 1ns/1ps
module tb_dto_pixclk_gen;
  localparam logic [23:0] LO = 24'd838861;
  localparam logic [23:0] HI = 24'd4194304;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync_i = 1'b0;
  logic        hsync_pol_i = 1'b0;
  logic [23:0] inc_i = LO;
  logic [23:0] phase_ofs_i = '0;
  logic        pix_clk_o, pix_en_o, line_start_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [23:0] m_acc = '0;
  logic [23:0] m_inc = LO;
  logic        m_en = 1'b0;
  logic        m_ls = 1'b0;

  always #2.5 clk = ~clk;

  dto_pixclk_gen dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .hsync_i     (hsync_i),
    .hsync_pol_i (hsync_pol_i),
    .inc_i       (inc_i),
    .phase_ofs_i (phase_ofs_i),
    .pix_clk_o   (pix_clk_o),
    .pix_en_o    (pix_en_o),
    .line_start_o(line_start_o)
  );

  function automatic logic [23:0] lim(input logic [23:0] v);
    if (v < LO) return LO;
    if (v > HI) return HI;
    return v;
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                     input string req, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step(input bit load, input string req);
    logic [24:0] s;
    @(negedge clk);
    if (load) begin
      m_acc = phase_ofs_i; m_inc = lim(inc_i); m_en = 1'b0; m_ls = 1'b1;
    end else begin
      s = {1'b0, m_acc} + {1'b0, m_inc};
      m_acc = s[23:0]; m_en = s[24]; m_ls = 1'b0;
    end
    chk(32'(pix_en_o), 32'(m_en), req, "pix_en_o");
    chk(32'(pix_clk_o), 32'(m_acc[23]), req, "pix_clk_o");
    chk(32'(line_start_o), 32'(m_ls), req, "line_start_o");
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, req);
  endtask

  // active edge, load on the third clock edge, then back to idle level
  task automatic sync_line(input string req);
    logic act;
    act = ~hsync_pol_i;
    hsync_i = act;
    step(1'b0, req); step(1'b0, req); step(1'b1, req);
    run(4, req);
    hsync_i = ~act;
    run(4, req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(32'(pix_en_o), 0, "R1", "pix_en_o in reset");
    chk(32'(line_start_o), 0, "R1", "line_start_o in reset");
    chk(32'(pix_clk_o), 0, "R1", "pix_clk_o in reset");
    rst_ni = 1'b1;
    run(25, "R1");  // carry at step 20 from lower limit
  endtask

  task automatic t_basic;
    inc_i = 24'd2000000; phase_ofs_i = '0;
    sync_line("R2");
    run(40, "R5");
  endtask

  task automatic t_offset;
    phase_ofs_i = 24'hC00000; inc_i = 24'd3000000;
    sync_line("R4");
    run(20, "R6");
    phase_ofs_i = 24'h000000;
  endtask

  task automatic t_pol;
    hsync_pol_i = 1'b1;
    @(negedge clk);
    begin
      logic [24:0] s;
      s = {1'b0, m_acc} + {1'b0, m_inc};
      m_acc = s[23:0]; m_en = s[24]; m_ls = 1'b0;
    end
    hsync_i = 1'b1;   // inactive for falling polarity
    run(8, "R3");
    inc_i = 24'd1500000;
    hsync_i = 1'b0;   // active falling edge
    step(1'b0, "R2"); step(1'b0, "R2"); step(1'b1, "R2");
    run(10, "R2");
    hsync_pol_i = 1'b0;
    run(3, "R3");
    hsync_i = 1'b1;   // falling polarity restored to rising: this is active
    step(1'b0, "R2"); step(1'b0, "R2"); step(1'b1, "R2");
    run(4, "R2");
    hsync_i = 1'b0;   // inactive falling edge
    run(6, "R3");
  endtask

  task automatic t_inc_hold;
    inc_i = 24'd1000000;
    sync_line("R7");
    inc_i = 24'd4000000;
    run(60, "R7");
    sync_line("R7");
    run(20, "R7");
  endtask

  task automatic t_clamp;
    inc_i = 24'd1;
    sync_line("R8");
    run(30, "R8");
    inc_i = 24'hFFFFFF;
    sync_line("R8");
    run(30, "R8");
  endtask

  task automatic t_coincide;
    inc_i = HI; phase_ofs_i = '0;
    hsync_i = 1'b1;
    step(1'b0, "R4"); step(1'b0, "R4"); step(1'b1, "R4");   // m=0
    run(2, "R4");                                           // m=1,2
    hsync_i = 1'b0;
    run(3, "R5");                                           // m=3..5, carry at m=4
    hsync_i = 1'b1;
    step(1'b0, "R4"); step(1'b0, "R4");                     // m=6,7
    step(1'b1, "R4");                                       // m=8 load vs carry
    chk(32'(pix_en_o), 0, "R4", "pix_en_o on coincident load");
    run(8, "R5");
    hsync_i = 1'b0;
    run(4, "R5");
  endtask

  task automatic t_average;
    int cnt;
    longint exp;
    inc_i = 24'd1000000; phase_ofs_i = '0;
    hsync_i = 1'b1;
    step(1'b0, "R9"); step(1'b0, "R9"); step(1'b1, "R9");
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      step(1'b0, "R9");
      if (pix_en_o) cnt++;
    end
    exp = (longint'(1000) * 1000000) >> 24;
    chk(32'(cnt), 32'(exp), "R9", "pixel count over 1000 cycles");
    hsync_i = 1'b0;
    run(4, "R9");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_offset();
    t_pol();
    t_inc_hold();
    t_clamp();
    t_coincide();
    t_average();
    summary();
    $finish;
  end
endmodule